// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This block inspects one floating-point word and decides whether it holds a quiet NaN, a signaling NaN, or neither. The word can be half precision, bfloat16, single or double. For the same word it also produces a quieted copy and a default NaN pattern for the selected format. All results are registered once at the output, so they appear one clock after the inputs.

Two mode inputs set how the block reads the fraction MSB, which is the bit that separates quiet from signaling NaNs:

- The polarity mode chooses between the 2008 convention (MSB set means quiet) and the legacy convention (MSB set means signaling).
- The second mode turns signaling detection off, so that every NaN is reported as quiet.

A sign-select input sets the sign of the default NaN. The block is meant to sit next to a floating-point datapath, where it settles NaN handling before or after arithmetic.

Top module: `nan_quieter`

## Requirements
- R1: `fmtSel` picks the layout. 0 is half: sign 15, exponent [14:10], fraction [9:0]. 1 is bfloat16: sign 15, exponent [14:7], fraction [6:0]. 2 is single: sign 31, exponent [30:23], fraction [22:0]. 3 is double: sign 63, exponent [62:52], fraction [51:0]. Input bits above the format width are ignored, and every output word is zero above that width.
- R2: A word whose exponent is not all ones, or whose fraction is zero, drives `outQuiet` and `outSignaling` both low. The two flags are never high together.
- R3: In the 2008 convention (`legacyMode`=0) a NaN with the fraction MSB set is quiet, and a NaN with it clear is signaling.
- R4: In the legacy convention (`legacyMode`=1) a NaN with the fraction MSB clear is quiet, and a NaN with it set is signaling.
- R5: With `noSnanMode`=1, every NaN reports `outQuiet`=1, and `outSignaling` stays 0 whatever the polarity.
- R6: For a signaling NaN, `outQuieted` is the input with the fraction MSB set in the 2008 convention. In the legacy convention it is the input with the fraction MSB cleared and the next lower fraction bit set.
- R7: For any input that is not a signaling NaN, `outQuieted` equals the input masked to the format width. Quieting never changes the sign bit.
- R8: `outDefault` has an all-ones exponent and its sign taken from `defNanSign`. Its fraction is the MSB alone in the 2008 convention, and every fraction bit except the MSB in the legacy convention.
- R9: Every output reflects the inputs of the previous clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inWord | input | 64 | Word to classify, right-aligned |
| fmtSel | input | 2 | Format: 0 half, 1 bfloat16, 2 single, 3 double |
| legacyMode | input | 1 | 1 = set fraction MSB means signaling |
| noSnanMode | input | 1 | 1 = every NaN counts as quiet |
| defNanSign | input | 1 | Sign bit of the default NaN |
| outQuiet | output | 1 | Input was a quiet NaN |
| outSignaling | output | 1 | Input was a signaling NaN |
| outQuieted | output | 64 | Quieted copy, or the input unchanged |
| outDefault | output | 64 | Default NaN for the format and polarity |

## Verification
Classification and quieting act on the same word in the same cycle. With the polarity flipped between back-to-back words, the flags and the quieted word must therefore follow one mode value together. The bench drives sequences that hold the word fixed and toggle `legacyMode` or `noSnanMode` on every cycle. It then checks that the flags, the quieted word and the default NaN all match a reference model of the same cycle's modes. These sequences cover the legacy MSB-only NaN, whose quieted form must become a quiet NaN rather than infinity.

// File: rtl/nan_quieter_pkg.sv
package nan_quieter_pkg;

  localparam int WORD_W = 64;
  localparam int NUM_FMT = 4;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmtKind_t;

  typedef struct packed {
    logic [WORD_W-1:0] widthMask;
    logic [WORD_W-1:0] expMask;
    logic [WORD_W-1:0] fracMask;
    logic [WORD_W-1:0] msbBit;
    logic [WORD_W-1:0] nextBit;
    logic [WORD_W-1:0] signBit;
  } layout_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    legacy;
    logic    noSnan;
    logic    defSign;
    layout_t lay;
  } ctrlStrobes_t;

  function automatic int expWidth(input int f);
    case (f)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fracWidth(input int f);
    case (f)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic layout_t buildLayout(input int f);
    layout_t l;
    int ew;
    int fw;
    ew = expWidth(f);
    fw = fracWidth(f);
    l.fracMask  = (64'd1 << fw) - 64'd1;
    l.expMask   = ((64'd1 << ew) - 64'd1) << fw;
    l.msbBit    = 64'd1 << (fw - 1);
    l.nextBit   = 64'd1 << (fw - 2);
    l.signBit   = 64'd1 << (ew + fw);
    l.widthMask = l.signBit | (l.signBit - 64'd1);
    return l;
  endfunction

endpackage

// File: rtl/nan_quieter_ctrl.sv
module nan_quieter_ctrl
  import nan_quieter_pkg::*;
(
  input  logic         [1:0] fmtSel,
  input  logic               legacyMode,
  input  logic               noSnanMode,
  input  logic               defNanSign,
  output ctrlStrobes_t       strobes
);

  layout_t layTab [NUM_FMT];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_layout
    assign layTab[f] = buildLayout(f);
  end

  fmtKind_t fmtK;
  assign fmtK = fmtKind_t'(fmtSel);

  always_comb begin
    strobes.legacy  = legacyMode;
    strobes.noSnan  = noSnanMode;
    strobes.defSign = defNanSign;
    case (fmtK)
      FMT_HALF:   strobes.lay = layTab[0];
      FMT_BF16:   strobes.lay = layTab[1];
      FMT_SINGLE: strobes.lay = layTab[2];
      default:    strobes.lay = layTab[3];
    endcase
  end

endmodule

// File: rtl/nan_quieter_dp.sv
module nan_quieter_dp
  import nan_quieter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   inWord,
  input  ctrlStrobes_t        strobes,
  output logic                outQuiet,
  output logic                outSignaling,
  output logic [WORD_W-1:0]   outQuieted,
  output logic [WORD_W-1:0]   outDefault
);

  logic [WORD_W-1:0] inner;
  logic              expOnes;
  logic              fracNz;
  logic              isNan;
  logic              msbSet;
  logic              quietNext;
  logic              sigNext;
  logic [WORD_W-1:0] silenced;
  logic [WORD_W-1:0] quietedNext;
  logic [WORD_W-1:0] defaultNext;

  always_comb begin
    inner   = inWord & strobes.lay.widthMask;
    expOnes = (inner & strobes.lay.expMask) == strobes.lay.expMask;
    fracNz  = |(inner & strobes.lay.fracMask);
    isNan   = expOnes && fracNz;
    msbSet  = |(inner & strobes.lay.msbBit);
    // signaling when MSB matches the legacy polarity
    sigNext   = isNan && !strobes.noSnan && (msbSet == strobes.legacy);
    quietNext = isNan && !sigNext;
    if (strobes.legacy)
      silenced = (inner & ~strobes.lay.msbBit) | strobes.lay.nextBit;
    else
      silenced = inner | strobes.lay.msbBit;
    quietedNext = sigNext ? silenced : inner;
    defaultNext = strobes.lay.expMask
                | (strobes.legacy ? (strobes.lay.fracMask & ~strobes.lay.msbBit)
                                  : strobes.lay.msbBit)
                | (strobes.defSign ? strobes.lay.signBit : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outQuiet     <= 1'b0;
      outSignaling <= 1'b0;
      outQuieted   <= '0;
      outDefault   <= '0;
    end else begin
      outQuiet     <= quietNext;
      outSignaling <= sigNext;
      outQuieted   <= quietedNext;
      outDefault   <= defaultNext;
    end
  end

  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(outQuiet && outSignaling)); // R2

  AST_NOSNAN_NO_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.noSnan) && $past(rst_n) |-> !outSignaling); // R5

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
    ((outQuieted & $past(strobes.lay.signBit)) ==
     ($past(inWord) & $past(strobes.lay.signBit)))); // R7

  AST_DEFAULT_EXP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
    ((outDefault & $past(strobes.lay.expMask)) == $past(strobes.lay.expMask))); // R8

  AST_OUT_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |->
    ((outQuieted & ~$past(strobes.lay.widthMask)) == '0)); // R1

endmodule

// File: rtl/nan_quieter.sv
module nan_quieter
  import nan_quieter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] inWord,
  input  logic [1:0]  fmtSel,
  input  logic        legacyMode,
  input  logic        noSnanMode,
  input  logic        defNanSign,
  output logic        outQuiet,
  output logic        outSignaling,
  output logic [63:0] outQuieted,
  output logic [63:0] outDefault
);

  ctrlStrobes_t strobes;

  nan_quieter_ctrl i_ctrl (
    .fmtSel     (fmtSel),
    .legacyMode (legacyMode),
    .noSnanMode (noSnanMode),
    .defNanSign (defNanSign),
    .strobes    (strobes)
  );

  nan_quieter_dp i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .inWord       (inWord),
    .strobes      (strobes),
    .outQuiet     (outQuiet),
    .outSignaling (outSignaling),
    .outQuieted   (outQuieted),
    .outDefault   (outDefault)
  );

endmodule

// File: tb/test_nan_quieter.sv
module test_nan_quieter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] inWord = '0;
  logic [1:0]  fmtSel = '0;
  logic        legacyMode = 1'b0;
  logic        noSnanMode = 1'b0;
  logic        defNanSign = 1'b0;
  logic        outQuiet;
  logic        outSignaling;
  logic [63:0] outQuieted;
  logic [63:0] outDefault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  nan_quieter i_nan_quieter (
    .clk(clk), .rst_n(rst_n), .inWord(inWord), .fmtSel(fmtSel),
    .legacyMode(legacyMode), .noSnanMode(noSnanMode), .defNanSign(defNanSign),
    .outQuiet(outQuiet), .outSignaling(outSignaling),
    .outQuieted(outQuieted), .outDefault(outDefault)
  );

  typedef struct {
    string       tag;
    logic        q;
    logic        s;
    logic [63:0] qw;
    logic [63:0] dn;
  } expect_t;

  expect_t sb[$];

  function automatic expect_t model(input logic [63:0] w, input int f,
                                    input logic leg, input logic nos,
                                    input logic ds, input string tag);
    expect_t e;
    int ew, fw;
    logic [63:0] x, ex, fr, allE, fm, msb, nxt, sgn, wm;
    logic nan, sig;
    case (f)
      0: begin ew = 5;  fw = 10; end
      1: begin ew = 8;  fw = 7;  end
      2: begin ew = 8;  fw = 23; end
      default: begin ew = 11; fw = 52; end
    endcase
    wm   = (ew + fw + 1 == 64) ? '1 : ((64'd1 << (ew + fw + 1)) - 1);
    x    = w & wm;
    fm   = (64'd1 << fw) - 1;
    allE = (64'd1 << ew) - 1;
    ex   = (x >> fw) & allE;
    fr   = x & fm;
    msb  = 64'd1 << (fw - 1);
    nxt  = 64'd1 << (fw - 2);
    sgn  = 64'd1 << (ew + fw);
    nan  = (ex == allE) && (fr != 0);
    sig  = nan && !nos && (((fr & msb) != 0) == leg);
    e.tag = tag;
    e.s   = sig;
    e.q   = nan && !sig;
    e.qw  = !sig ? x : (leg ? ((x & ~msb) | nxt) : (x | msb));
    e.dn  = (allE << fw) | (leg ? (fm & ~msb) : msb) | (ds ? sgn : 64'd0);
    return e;
  endfunction

  task automatic drive(input logic [63:0] w, input int f, input logic leg,
                       input logic nos, input logic ds, input string tag);
    @(negedge clk);
    inWord = w; fmtSel = f[1:0]; legacyMode = leg; noSnanMode = nos; defNanSign = ds;
    sb.push_back(model(w, f, leg, nos, ds, tag));
  endtask

  // monitor: compares one cycle after each drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb.size() > 0) begin
        expect_t e;
        e = sb.pop_front();
        checks++;
        if (outQuiet !== e.q || outSignaling !== e.s ||
            outQuieted !== e.qw || outDefault !== e.dn) begin
          errors++;
          $display("FAIL %s: got q=%b s=%b qw=%h dn=%h exp q=%b s=%b qw=%h dn=%h",
                   e.tag, outQuiet, outSignaling, outQuieted, outDefault,
                   e.q, e.s, e.qw, e.dn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    inWord = 64'h7FF8_0000_0000_0001; defNanSign = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R9 reset state
    if (outQuiet !== 0 || outSignaling !== 0 || outQuieted !== 0 || outDefault !== 0) begin
      errors++;
      $display("FAIL R9 reset: q=%b s=%b qw=%h dn=%h exp all zero",
               outQuiet, outSignaling, outQuieted, outDefault);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 non-NaN: infinity, zero, normal
    drive(64'h7C00, 0, 0, 0, 0, "R2 half inf");
    drive(64'h0000, 2, 1, 0, 1, "R2 single zero");
    drive(64'h3FF0_0000_0000_0000, 3, 0, 0, 0, "R2 double one");
    // R3 2008 convention
    drive(64'h7E00, 0, 0, 0, 0, "R3 half quiet");
    drive(64'h7C01, 0, 0, 0, 0, "R3 half signaling");
    drive(64'h7FC0, 1, 0, 0, 0, "R3 bf16 quiet");
    drive(64'h7F81, 1, 0, 0, 0, "R3 bf16 signaling");
    drive(64'hFFC0_0000, 2, 0, 0, 0, "R3 single quiet neg");
    drive(64'h7FF0_0000_0000_0001, 3, 0, 0, 0, "R3 double signaling");
    // R4 legacy
    drive(64'h7FC0_0000, 2, 1, 0, 0, "R4 single msb set signaling");
    drive(64'h7F80_0001, 2, 1, 0, 0, "R4 single msb clear quiet");
    drive(64'h7FF8_0000_0000_0000, 3, 1, 0, 1, "R4 double msb-only");
    // R5 no-signaling mode
    drive(64'h7C01, 0, 0, 1, 0, "R5 half");
    drive(64'h7FC0_0000, 2, 1, 1, 0, "R5 single legacy");
    // R6 quieting
    drive(64'hFF80_0005, 2, 0, 0, 0, "R6 single 2008");
    drive(64'h7E00, 0, 1, 0, 0, "R6 half legacy msb-only");
    // R1 upper bits ignored
    drive(64'hDEAD_BEEF_1234_7C01, 0, 0, 0, 0, "R1 half upper junk");
    drive(64'hFFFF_FFFF_FFFF_FF81, 1, 1, 0, 1, "R1 bf16 upper junk");
    // R7 passthrough
    drive(64'hBF80_0000, 2, 0, 0, 0, "R7 single normal passthru");
    // R8 default NaN variants
    drive(64'h0, 3, 1, 0, 1, "R8 double legacy sign");
    drive(64'h0, 1, 0, 0, 1, "R8 bf16 2008 sign");
    // mode toggling on a fixed word
    for (int i = 0; i < 16; i++)
      drive(64'h7FC0_0000, 2, i[0], i[1], i[2], "R4 toggle modes");
    for (int i = 0; i < 16; i++)
      drive(64'h7FF8_0000_0000_0000, 3, i[0], i[1], i[3], "R6 toggle modes");
    // random, NaN-heavy
    for (int i = 0; i < 600; i++) begin
      logic [63:0] w;
      int f;
      w = {$urandom, $urandom};
      f = int'($urandom_range(0, 3));
      if (i % 2 == 0) w = w | 64'h7FFF_FFFF_FFFF_FFFF & ~64'h000F_FFFF_FFFF_FFFF & 64'h7FF0_0000_0000_0000 | (f == 0 ? 64'h7C00 : f == 1 ? 64'h7F80 : f == 2 ? 64'h7F80_0000 : 64'h7FF0_0000_0000_0000);
      drive(w, f, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), "R3 random");
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule